// File: doc/BRIEF.md
# Residue Channel Multiply-Accumulate Unit

This block is one lane of a parallel residue-number-system arithmetic engine. Each lane works modulo its own pseudo-Mersenne modulus `m = 2^W - C`, where C is small. Every cycle the lane can start one operation. The operation multiplies two operands, reduces the product modulo m, and either adds it to a running accumulator or replaces the accumulator with it. The result goes into a 16-entry register file, and any register can be placed on the shared bus for the neighbouring lanes.

Each operand can come from one of three places: a register, the shared bus input (used during base-extension accumulation, where lane j's value is on the bus in cycle j), or a constant port. The modular product needs no division and no trial subtraction of the full product. The upper half of the product is folded back twice, using the identity `2^W ≡ C (mod m)`, and then narrow modulo adders finish the result. The pipeline is six stages deep. It accepts a new operation every cycle and has no interlock. The external sequencer must not read a register whose write is still in flight.

Top module: `rns_mac_unit`

## Requirements
- R1: After reset, `resValid` is 0, `resOut` is 0, and every register reads as 0 on `busOut`.
- R2: With `accClear` = 1, the result equals `(a*b) mod m` for any operands a, b in [0, 2^W-1]. This includes 0, m-1 and 2^W-1. Every reported result is below m.
- R3: The result appears on `resOut` with `resValid` = 1 exactly 6 clock edges after the edge that samples the issuing `opValid`. `resValid` is high for one cycle per operation.
- R4: Operations issued on consecutive cycles all complete, one per cycle, in issue order.
- R5: With `accClear` = 0, the result equals `(a*b + prev) mod m`, where prev is the result of the operation that completed just before it. This holds even when that operation completed in the immediately preceding cycle.
- R6: Each result is written to register `dstSel`. A later operation can read it as an operand through select code 0..15, which is the register index.
- R7: `busOut` equals register `outSel` while `outEn` = 1, and equals 0 while `outEn` = 0.
- R8: Operand select code 16 takes `busIn`, code 17 takes `constIn`, and codes 18..31 give the operand 0.
- R9: A cycle with `opValid` = 0 produces no `resValid`. It changes neither the accumulator nor any register.
- R10: An operand read of a register whose write is still in the pipeline returns the register's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Issue one operation this cycle |
| srcASel | input | 5 | First operand select: 0..15 register, 16 bus, 17 constant |
| srcBSel | input | 5 | Second operand select, same coding |
| dstSel | input | 4 | Destination register of the result |
| accClear | input | 1 | Replace the accumulator instead of adding to it |
| busIn | input | W | Shared bus value from the lanes |
| constIn | input | W | Constant operand |
| outEn | input | 1 | Drive a register onto `busOut` |
| outSel | input | 4 | Register driven onto `busOut` |
| busOut | output | W | Register value for the shared bus, 0 when idle |
| resValid | output | 1 | A result completed this cycle |
| resOut | output | W | Accumulator value, the latest result |

## Verification
The bench runs a small lane with W = 6 and C = 3, so m = 61. This makes the product sweep exhaustive. Every pair of 6-bit bus and constant operands is issued back to back with the accumulator cleared. That covers the second fold and both subtractions of the wide adder, as well as the values 0, m-1 and 2^W-1 that sit above the modulus. A pseudo-random chain with `accClear` low and idle gaps separates true back-to-back accumulation from accumulation that skips or repeats a term. Register-sourced pairs, bus read-back and a deliberate read-after-write in flight separate correct write-back and select decoding from stale or premature register contents.

// File: rtl/rns_mac_pkg.sv
package rns_mac_pkg;

  localparam int REG_CNT    = 16;
  localparam int IDX_W      = 4;
  localparam int SEL_W      = 5;
  localparam int PIPE_DEPTH = 6;

  localparam logic [SEL_W-1:0] SEL_BUS   = 5'd16;
  localparam logic [SEL_W-1:0] SEL_CONST = 5'd17;

  // strobes that travel beside the datapath, one set per operation
  typedef struct packed {
    logic             issue;
    logic             clear;
    logic [IDX_W-1:0] dst;
  } ctlStrobe_t;

endpackage

// File: rtl/rns_mac_ctl.sv
module rns_mac_ctl
  import rns_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic             accClear,
  input  logic [IDX_W-1:0] dstSel,
  output ctlStrobe_t       wbCtl
);

  localparam int CTL_STAGES = PIPE_DEPTH - 1;

  ctlStrobe_t ctlPipe [CTL_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctlPipe[0] <= '0;
    else        ctlPipe[0] <= '{issue: opValid, clear: accClear, dst: dstSel};
  end

  for (genvar i = 1; i < CTL_STAGES; i++) begin : g_shift
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctlPipe[i] <= '0;
      else        ctlPipe[i] <= ctlPipe[i-1];
    end
  end

  // strobe for the operation entering the final (write-back) stage
  assign wbCtl = ctlPipe[CTL_STAGES-1];

endmodule

// File: rtl/rns_mac_dp.sv
module rns_mac_dp
  import rns_mac_pkg::*;
#(
  parameter int          W  = 17,
  parameter int          CW = 8,
  parameter int unsigned C  = 31
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] srcASel,
  input  logic [SEL_W-1:0] srcBSel,
  input  logic [W-1:0]     busIn,
  input  logic [W-1:0]     constIn,
  input  logic             outEn,
  input  logic [IDX_W-1:0] outSel,
  input  ctlStrobe_t       wbCtl,
  output logic [W-1:0]     busOut,
  output logic             resValid,
  output logic [W-1:0]     resOut
);

  localparam int unsigned MOD    = (2**W) - C;
  localparam logic [W+1:0] MOD_X  = (W+2)'(MOD);
  localparam logic [W+1:0] MOD_2X = (W+2)'(2*MOD);
  localparam logic [W-1:0] MOD_W  = W'(MOD);
  localparam logic [W+CW-1:0] C_MID = (W+CW)'(C);
  localparam logic [2*CW-1:0] C_LOW = (2*CW)'(C);

  logic [W-1:0] regFile [REG_CNT];

  // single conditional subtraction: input below 2^W
  function automatic logic [W-1:0] foldOnce(input logic [W-1:0] v);
    return (v >= MOD_W) ? v - MOD_W : v;
  endfunction

  // both inputs below 2^W: up to two subtractions of m
  function automatic logic [W-1:0] modAddWide(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W+1:0] s;
    s = (W+2)'(a) + (W+2)'(b);
    if (s >= MOD_2X)     return W'(s - MOD_2X);
    else if (s >= MOD_X) return W'(s - MOD_X);
    else                 return W'(s);
  endfunction

  // both inputs below m: one subtraction
  function automatic logic [W-1:0] modAddNarrow(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = (W+1)'(a) + (W+1)'(b);
    return (s >= (W+1)'(MOD)) ? W'(s - (W+1)'(MOD)) : W'(s);
  endfunction

  function automatic logic [W-1:0] pickOperand(input logic [SEL_W-1:0] sel);
    if (!sel[SEL_W-1])         return regFile[sel[IDX_W-1:0]];
    else if (sel == SEL_BUS)   return busIn;
    else if (sel == SEL_CONST) return constIn;
    else                       return '0;
  endfunction

  // stage registers
  logic [W-1:0]    s1A, s1B;
  logic [2*W-1:0]  s2P;
  logic [W+CW-1:0] s3Q;
  logic [W-1:0]    s3R;
  logic [2*CW-1:0] s4Rp;
  logic [W-1:0]    s4S;
  logic [W-1:0]    s5T;
  logic [W-1:0]    accReg;

  logic [2*W-1:0]  prodFull;
  logic [W+CW-1:0] firstFold;
  logic [2*CW-1:0] secondFold;
  logic [W-1:0]    accNext;

  assign prodFull   = (2*W)'(s1A) * (2*W)'(s1B);                 // W x W
  assign firstFold  = (W+CW)'(s2P[2*W-1:W]) * C_MID;             // W x CW
  assign secondFold = (2*CW)'(s3Q[W+CW-1:W]) * C_LOW;            // CW x CW
  assign accNext    = wbCtl.clear ? s5T : modAddNarrow(s5T, accReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1A  <= '0;
      s1B  <= '0;
      s2P  <= '0;
      s3Q  <= '0;
      s3R  <= '0;
      s4Rp <= '0;
      s4S  <= '0;
      s5T  <= '0;
    end else begin
      s1A  <= pickOperand(srcASel);
      s1B  <= pickOperand(srcBSel);
      s2P  <= prodFull;
      s3Q  <= firstFold;
      s3R  <= foldOnce(s2P[W-1:0]);
      s4Rp <= secondFold;
      s4S  <= modAddWide(s3Q[W-1:0], s3R);
      s5T  <= modAddWide(W'(s4Rp), s4S);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accReg   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= wbCtl.issue;
      if (wbCtl.issue) accReg <= accNext;
    end
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regFile[g] <= '0;
      else if (wbCtl.issue && (wbCtl.dst == IDX_W'(g)))
        regFile[g] <= accNext;
    end
  end

  assign busOut = outEn ? regFile[outSel] : '0;
  assign resOut = accReg;

endmodule

// File: rtl/rns_mac_unit.sv
module rns_mac_unit
  import rns_mac_pkg::*;
#(
  parameter int          W  = 17,
  parameter int          CW = 8,
  parameter int unsigned C  = 31
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         opValid,
  input  logic [4:0]   srcASel,
  input  logic [4:0]   srcBSel,
  input  logic [3:0]   dstSel,
  input  logic         accClear,
  input  logic [W-1:0] busIn,
  input  logic [W-1:0] constIn,
  input  logic         outEn,
  input  logic [3:0]   outSel,
  output logic [W-1:0] busOut,
  output logic         resValid,
  output logic [W-1:0] resOut
);

  ctlStrobe_t wbCtl;

  rns_mac_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .accClear (accClear),
    .dstSel   (dstSel),
    .wbCtl    (wbCtl)
  );

  rns_mac_dp #(.W(W), .CW(CW), .C(C)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .srcASel  (srcASel),
    .srcBSel  (srcBSel),
    .busIn    (busIn),
    .constIn  (constIn),
    .outEn    (outEn),
    .outSel   (outSel),
    .wbCtl    (wbCtl),
    .busOut   (busOut),
    .resValid (resValid),
    .resOut   (resOut)
  );

endmodule

// File: rtl/rns_mac_chk.sv
module rns_mac_chk #(
  parameter int          W = 17,
  parameter int unsigned C = 31
)(
  input logic         clk,
  input logic         rst_n,
  input logic         opValid,
  input logic         outEn,
  input logic [W-1:0] busOut,
  input logic         resValid,
  input logic [W-1:0] resOut
);

  localparam logic [W-1:0] MOD_W = W'((2**W) - C);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R3: completion follows issue by exactly six edges
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd6) |-> (resValid == $past(opValid, 6)));

  // R2: every completed result is a reduced residue
  assert_residue_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resValid |-> (resOut < MOD_W));

  // R7: idle bus drives zero
  assert_bus_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !outEn |-> (busOut == '0));

  // R9: without a completion the accumulator holds
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sinceRst >= 3'd1) && !resValid) |-> $stable(resOut));

endmodule

bind rns_mac_unit rns_mac_chk #(.W(W), .C(C)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opValid  (opValid),
  .outEn    (outEn),
  .busOut   (busOut),
  .resValid (resValid),
  .resOut   (resOut)
);

// File: tb/sim_rns_mac_unit.sv
module sim_rns_mac_unit;

  localparam int W   = 6;
  localparam int CW  = 2;
  localparam int C   = 3;
  localparam int MOD = (2**W) - C;   // 61
  localparam int QMAX = 8192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         opValid = 1'b0;
  logic [4:0]   srcASel = '0;
  logic [4:0]   srcBSel = '0;
  logic [3:0]   dstSel = '0;
  logic         accClear = 1'b0;
  logic [W-1:0] busIn = '0;
  logic [W-1:0] constIn = '0;
  logic         outEn = 1'b0;
  logic [3:0]   outSel = '0;
  logic [W-1:0] busOut;
  logic         resValid;
  logic [W-1:0] resOut;

  rns_mac_unit #(.W(W), .CW(CW), .C(C)) u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .srcASel(srcASel),
    .srcBSel(srcBSel), .dstSel(dstSel), .accClear(accClear), .busIn(busIn),
    .constIn(constIn), .outEn(outEn), .outSel(outSel), .busOut(busOut),
    .resValid(resValid), .resOut(resOut)
  );

  always #10 clk = ~clk;   // 50 MHz

  int    nChecks = 0;
  int    nFails  = 0;
  int    cyc     = 0;
  bit    monOn   = 1'b0;
  bit    done    = 1'b0;

  int    expVal [QMAX];
  int    expCyc [QMAX];
  string expTag [QMAX];
  int    wrPtr = 0;
  int    rdPtr = 0;

  int    rfModel [16];
  int    accModel = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // result monitor: compare every completion against the queued expectation
  always @(negedge clk) begin
    if (monOn && resValid) begin
      if (rdPtr >= wrPtr) begin
        check(1'b0, "R9 unexpected completion", int'(resOut), -1);
      end else begin
        check(int'(resOut) == expVal[rdPtr], expTag[rdPtr], int'(resOut), expVal[rdPtr]);
        check(cyc - expCyc[rdPtr] == 6, "R3 latency", cyc - expCyc[rdPtr], 6);
        rdPtr++;
      end
    end
  end

  function automatic int operandOf(input int sel, input int bv, input int cv);
    if (sel < 16)  return rfModel[sel];
    if (sel == 16) return bv;
    if (sel == 17) return cv;
    return 0;   // R8: codes 18..31 give zero
  endfunction

  task automatic issue(input int sa, input int sb, input int d, input bit clr,
                       input int bv, input int cv, input int forceExp, input string tag);
    int a, b, e;
    @(negedge clk);
    a = operandOf(sa, bv, cv);
    b = operandOf(sb, bv, cv);
    if (forceExp >= 0) e = forceExp;
    else if (clr)      e = (a * b) % MOD;
    else               e = (a * b + accModel) % MOD;
    accModel = e;
    rfModel[d] = e;
    opValid  = 1'b1;
    srcASel  = 5'(sa);
    srcBSel  = 5'(sb);
    dstSel   = 4'(d);
    accClear = clr;
    busIn    = W'(bv);
    constIn  = W'(cv);
    expVal[wrPtr] = e;
    expCyc[wrPtr] = cyc;
    expTag[wrPtr] = tag;
    wrPtr++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      opValid = 1'b0;
    end
  endtask

  task automatic checkBus(input bit en, input int idx, input int exp, input string tag);
    @(negedge clk);
    opValid = 1'b0;
    outEn   = en;
    outSel  = 4'(idx);
    #5;
    check(int'(busOut) == exp, tag, int'(busOut), exp);
    outEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    int lfsr;
    int oldV;
    for (int i = 0; i < 16; i++) rfModel[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monOn = 1'b1;

    // R1: reset state at the ports
    @(negedge clk);
    check(resValid == 1'b0, "R1 resValid after reset", int'(resValid), 0);
    check(resOut == '0, "R1 resOut after reset", int'(resOut), 0);
    for (int i = 0; i < 16; i++) checkBus(1'b1, i, 0, "R1 register after reset");

    // R2 and R4: exhaustive bus x constant sweep, back to back, accumulator cleared
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        issue(16, 17, (a + b) % 16, 1'b1, a, b, -1, "R2/R4 sweep product");
    idle(8);

    // R8: unused select codes give zero operands
    issue(18, 17, 0, 1'b1, 0, 5, -1, "R8 zero select A");
    issue(17, 31, 1, 1'b1, 0, 7, -1, "R8 zero select B");
    issue(17, 16, 2, 1'b1, 9, 7, -1, "R8 bus and const order");
    idle(8);

    // R5 and R9: accumulation chain with pseudo-random idle gaps
    lfsr = 32'h1d3;
    issue(16, 17, 4, 1'b1, 63, 63, -1, "R5 chain seed");
    for (int k = 0; k < 600; k++) begin
      lfsr = ((lfsr << 1) ^ (((lfsr >> 9) ^ (lfsr >> 4)) & 1)) & 32'h3ff;
      if ((lfsr & 7) == 0) idle(1 + (lfsr >> 7));
      issue(16, 17, 4, 1'b0, lfsr & 63, (lfsr >> 4) & 63, -1,
            ((lfsr & 7) == 0) ? "R9 accumulate after gap" : "R5 accumulate");
    end
    idle(8);

    // R6: write known values to registers 0..14, read them back on the bus
    for (int i = 0; i < 15; i++)
      issue(16, 17, i, 1'b1, (i * 7 + 60) & 63, 1, -1, "R6 register load");
    idle(8);
    checkBus(1'b0, 5, 0, "R7 bus idle when disabled");
    for (int i = 0; i < 15; i++)
      checkBus(1'b1, i, rfModel[i], "R6/R7 register on bus");

    // R6 and R5: register-sourced pairs into register 15, mixed clear
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++)
        issue(i, j, 15, ((i + j) % 3) != 0, 0, 0, -1, "R6 register operands");
    idle(8);
    checkBus(1'b1, 15, rfModel[15], "R6 destination on bus");

    // R10: read of a register with its write still in flight returns the old value
    oldV = rfModel[3];
    issue(16, 17, 3, 1'b1, 40, 1, -1, "R10 pending write");
    issue(3, 17, 14, 1'b1, 0, 1, oldV, "R10 stale read");
    idle(8);
    checkBus(1'b1, 3, 40 % MOD, "R10 write lands later");
    checkBus(1'b1, 14, oldV, "R10 stale value stored");

    // R9: all issued operations completed, no extra completions after idle
    idle(10);
    check(rdPtr == wrPtr, "R9 completion count", rdPtr, wrPtr);
    check(int'(resOut) == accModel, "R9 accumulator holds when idle", int'(resOut), accModel);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule